// File: doc/BRIEF.md
# Capture and Match Timer

A 32-bit up-counting timer with a small register port. The count is advanced by a tick that is derived from one of three sources: every system clock, one clock in sixteen, or rising edges on an external pin. A programmable prescaler then divides that source. A reference word is compared against the counter. When the count reaches it, a match event is flagged, the output pin is pulsed for one clock or toggled, and either an interrupt level or a one-clock request strobe can be raised. In restart mode the counter returns to zero after the match; otherwise it keeps counting.

The same external pin also serves as a capture input. A chosen edge (rising, falling or both) copies the live count into a capture register and flags a capture event. Event flags are cleared by writing ones. A narrow mode limits the counter and the comparison to the low 16 bits.

Software drives the block through a word-indexed port: index 0 carries the mode halfword (bits 15:0), the extension byte (bits 23:16) and the event byte (bits 31:24). Index 1 is the reference, index 2 is the capture register and index 3 is the counter. Reads return data one clock after the read strobe.

Top module: `mct_timer`

## Requirements
- R1: While mode bit 0 is clear, the counter and the prescaler are held at zero and `tout` is low. A counter read returns 0.
- R2: Mode bits 2:1 pick the count source. 00 freezes the counter, 01 uses every system clock, 10 uses one clock in sixteen, and 11 uses rising edges of `tin` after a two-flop synchroniser.
- R3: Mode bits 15:8 hold a value P. The counter advances once per P+1 source events.
- R4: A match occurs when the counter steps onto the reference value. It sets event bit 1 (word 0 bit 25). With mode bit 3 set, the next tick returns the count to zero, so matches repeat every reference+1 ticks. With mode bit 3 clear, the count runs on past the reference.
- R5: With mode bit 5 clear, `tout` is high for exactly one clock per match. With it set, `tout` changes level at each match.
- R6: With mode bit 4 set and extension bit 7 clear, `irq` is high while event bit 1 is set. With extension bit 7 set, `irq` stays low and `dma_req` pulses for one clock per match instead.
- R7: Mode bits 7:6 select the capture edge on `tin`: 00 none, 01 rising, 10 falling, 11 both. A selected edge copies the count into the capture register and sets event bit 0 (word 0 bit 24). An edge that is not selected leaves both unchanged.
- R8: Writing 1 to an event bit through byte strobe 3 clears only that bit. Writing 0 leaves it unchanged.
- R9: Any write to word 3 resets the count and the prescaler phase to zero. After such a write, the first match arrives reference×(P+1)+1 clocks later.
- R10: Extension bit 0 selects narrow mode. The counter wraps from 0xFFFF to 0, and only the low 16 bits of the reference take part in the comparison.
- R11: After reset every register reads 0. Byte strobe b writes bits 8b+7:8b. Mode and extension read back as written, and reads return data on the clock after `rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 2 | Word index: 0 control, 1 reference, 2 capture, 3 counter |
| wr_en | input | 1 | Write strobe |
| wr_strb | input | 4 | Byte enables for the write |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Read data, valid the clock after rd_en |
| tin | input | 1 | External count source and capture input |
| tout | output | 1 | Match output, pulse or toggle |
| irq | output | 1 | Match interrupt level |
| dma_req | output | 1 | One-clock match request strobe |

## Verification
The hardest behaviours to reach are the 16-bit wrap and the capture of a known count value. The count can only be reset, never loaded, and it moves on every clock. The bench therefore runs the counter for a chosen number of cycles and then switches the source to stop. This freezes a known but distinct value in each capture-edge mode, so that both edges on `tin` can be checked for a copy or for no copy. Narrow mode is reached by setting a reference whose upper half is nonzero. The bench then measures the full 65536-clock gap between two matches.

// File: rtl/mct_pkg.sv
`timescale 1ns/1ps
package mct_pkg;
  localparam int BUS_W = 32;
  localparam int PS_W  = 8;

  typedef enum logic [1:0] {
    SRC_STOP = 2'b00,
    SRC_SYS  = 2'b01,
    SRC_DIV  = 2'b10,
    SRC_PIN  = 2'b11
  } src_e;

  // bit 0 = rising edge selected, bit 1 = falling edge selected
  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_e;

  typedef struct packed {
    logic [PS_W-1:0] presc;    // 15:8
    edge_e           cap_edge; // 7:6
    logic            toggle;   // 5
    logic            ref_irq;  // 4
    logic            restart;  // 3
    src_e            src;      // 2:1
    logic            run;      // 0
  } mode_t;

  localparam logic [1:0] WORD_CTRL = 2'd0;
  localparam logic [1:0] WORD_REF  = 2'd1;
  localparam logic [1:0] WORD_CAP  = 2'd2;
  localparam logic [1:0] WORD_CNT  = 2'd3;

  localparam int EV_CAP = 0;
  localparam int EV_REF = 1;
endpackage

// File: rtl/mct_pin_sync.sv
`timescale 1ns/1ps
module mct_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;
  logic              level;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign level = sync_q[STAGES-1];
  assign rise  = level & ~last_q;
  assign fall  = ~level & last_q;

  // an edge cannot be reported twice in a row from a single transition
  AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise); // R2
endmodule

// File: rtl/mct_tick_gen.sv
`timescale 1ns/1ps
module mct_tick_gen
  import mct_pkg::*;
#(
  parameter int PSW   = PS_W,
  parameter int DIV_N = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           run,
  input  logic           clr,
  input  src_e           src,
  input  logic           pin_rise,
  input  logic [PSW-1:0] presc,
  output logic           tick
);
  localparam int DIV_W = (DIV_N > 1) ? $clog2(DIV_N) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV_N - 1);

  logic [DIV_W-1:0] div_q;
  logic             div_pulse;
  logic             src_pulse;
  logic [PSW-1:0]   pre_q;

  always_ff @(posedge clk) begin
    if (rst || !run) div_q <= '0;
    else if (div_q == DIV_LAST) div_q <= '0;
    else div_q <= div_q + DIV_W'(1);
  end

  assign div_pulse = (div_q == DIV_LAST);

  always_comb begin
    case (src)
      SRC_SYS:  src_pulse = 1'b1;
      SRC_DIV:  src_pulse = div_pulse;
      SRC_PIN:  src_pulse = pin_rise;
      default:  src_pulse = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || !run || clr) begin
      pre_q <= '0;
      tick  <= 1'b0;
    end else begin
      tick <= 1'b0;
      if (src_pulse) begin
        if (pre_q >= presc) begin
          pre_q <= '0;
          tick  <= 1'b1;
        end else begin
          pre_q <= pre_q + PSW'(1);
        end
      end
    end
  end

  AST_NO_TICK_STOPPED: assert property (@(posedge clk) disable iff (rst)
    (src == SRC_STOP) |=> !tick); // R2
  AST_PRESC_GAP: assert property (@(posedge clk) disable iff (rst)
    tick |=> (!tick || $past(presc) == '0)); // R3
endmodule

// File: rtl/mct_core.sv
`timescale 1ns/1ps
module mct_core #(
  parameter int CNT_W    = 32,
  parameter int NARROW_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  input  logic             cnt_clr,
  input  logic             restart,
  input  logic             narrow,
  input  logic             toggle,
  input  logic [CNT_W-1:0] ref_val,
  input  logic             cap_fire,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cap,
  output logic             match_hit,
  output logic             tout
);
  localparam logic [CNT_W-1:0] NARROW_MASK = CNT_W'({NARROW_W{1'b1}});

  logic [CNT_W-1:0] mask;
  logic [CNT_W-1:0] ref_cmp;
  logic [CNT_W-1:0] cnt_inc;
  logic [CNT_W-1:0] cnt_nxt;
  logic             at_ref;
  logic             tog_q;
  logic             pulse_q;

  assign mask    = narrow ? NARROW_MASK : '1;
  assign ref_cmp = ref_val & mask;
  assign cnt_inc = (cnt + CNT_W'(1)) & mask;
  assign at_ref  = (cnt == ref_cmp);
  assign cnt_nxt = (restart && at_ref) ? '0 : cnt_inc;
  assign match_hit = run && tick && !cnt_clr && (cnt_nxt == ref_cmp);

  always_ff @(posedge clk) begin
    if (rst || !run)  cnt <= '0;
    else if (cnt_clr) cnt <= '0;
    else if (tick)    cnt <= cnt_nxt;
  end

  always_ff @(posedge clk) begin
    if (rst)           cap <= '0;
    else if (cap_fire) cap <= cnt;
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      tog_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= match_hit;
      if (match_hit) tog_q <= ~tog_q;
    end
  end

  assign tout = toggle ? tog_q : pulse_q;

  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    !run |=> (cnt == '0 && !tout)); // R1
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    (run && !tick && !cnt_clr) |=> $stable(cnt)); // R2
  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (rst)
    (tick && restart && at_ref && !cnt_clr) |=> (cnt == '0)); // R4
  AST_CAP_STABLE: assert property (@(posedge clk) disable iff (rst)
    !cap_fire |=> $stable(cap)); // R7
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
    cnt_clr |=> (cnt == '0)); // R9
endmodule

// File: rtl/mct_timer.sv
`timescale 1ns/1ps
module mct_timer
  import mct_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int DIV_N       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int NARROW_W    = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       addr,
  input  logic             wr_en,
  input  logic [3:0]       wr_strb,
  input  logic [BUS_W-1:0] wr_data,
  input  logic             rd_en,
  output logic [BUS_W-1:0] rd_data,
  input  logic             tin,
  output logic             tout,
  output logic             irq,
  output logic             dma_req
);
  localparam int NBYTE = BUS_W / 8;

  logic [15:0]      mode_q;
  mode_t            mode;
  logic [7:0]       ext_q;
  logic [1:0]       ev_q;
  logic [1:0]       ev_nxt;
  logic [BUS_W-1:0] ref_q;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cap;
  logic             cnt_clr;
  logic             wr_ctrl;
  logic             wr_ref;
  logic             pin_rise;
  logic             pin_fall;
  logic             tick;
  logic             match_hit;
  logic             cap_fire;
  logic             narrow;
  logic             dma_sel;
  logic             unused_wr_bits;

  assign mode    = mode_t'(mode_q);
  assign narrow  = ext_q[0];
  assign dma_sel = ext_q[7];
  assign wr_ctrl = wr_en && (addr == WORD_CTRL);
  assign wr_ref  = wr_en && (addr == WORD_REF);
  assign cnt_clr = wr_en && (addr == WORD_CNT) && (|wr_strb);
  assign unused_wr_bits = ^wr_data[31:26];

  // control word: mode halfword, extension byte, event byte (write-one-to-clear)
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      ext_q  <= '0;
    end else if (wr_ctrl) begin
      if (wr_strb[0]) mode_q[7:0]  <= wr_data[7:0];
      if (wr_strb[1]) mode_q[15:8] <= wr_data[15:8];
      if (wr_strb[2]) ext_q        <= wr_data[23:16];
    end
  end

  genvar gb;
  generate
    for (gb = 0; gb < NBYTE; gb++) begin : g_ref_byte
      always_ff @(posedge clk) begin
        if (rst) ref_q[8*gb +: 8] <= '0;
        else if (wr_ref && wr_strb[gb]) ref_q[8*gb +: 8] <= wr_data[8*gb +: 8];
      end
    end
  endgenerate

  mct_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .pin  (tin),
    .rise (pin_rise),
    .fall (pin_fall)
  );

  mct_tick_gen #(.PSW(PS_W), .DIV_N(DIV_N)) u_tick (
    .clk      (clk),
    .rst      (rst),
    .run      (mode.run),
    .clr      (cnt_clr),
    .src      (mode.src),
    .pin_rise (pin_rise),
    .presc    (mode.presc),
    .tick     (tick)
  );

  assign cap_fire = mode.run &&
                    ((pin_rise && mode.cap_edge[0]) || (pin_fall && mode.cap_edge[1]));

  mct_core #(.CNT_W(CNT_W), .NARROW_W(NARROW_W)) u_core (
    .clk       (clk),
    .rst       (rst),
    .run       (mode.run),
    .tick      (tick),
    .cnt_clr   (cnt_clr),
    .restart   (mode.restart),
    .narrow    (narrow),
    .toggle    (mode.toggle),
    .ref_val   (ref_q[CNT_W-1:0]),
    .cap_fire  (cap_fire),
    .cnt       (cnt),
    .cap       (cap),
    .match_hit (match_hit),
    .tout      (tout)
  );

  always_comb begin
    ev_nxt = ev_q;
    if (wr_ctrl && wr_strb[3]) ev_nxt = ev_nxt & ~wr_data[25:24];
    if (cap_fire)  ev_nxt[EV_CAP] = 1'b1;
    if (match_hit) ev_nxt[EV_REF] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ev_q    <= '0;
      dma_req <= 1'b0;
    end else begin
      ev_q    <= ev_nxt;
      dma_req <= match_hit && mode.ref_irq && dma_sel;
    end
  end

  assign irq = ev_q[EV_REF] && mode.ref_irq && !dma_sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      case (addr)
        WORD_CTRL: rd_data <= {6'b0, ev_q, ext_q, mode_q};
        WORD_REF:  rd_data <= ref_q;
        WORD_CAP:  rd_data <= BUS_W'(cap);
        default:   rd_data <= BUS_W'(cnt);
      endcase
    end
  end

  AST_MATCH_FLAG: assert property (@(posedge clk) disable iff (rst)
    match_hit |=> ev_q[EV_REF]); // R4
  AST_CAP_FLAG: assert property (@(posedge clk) disable iff (rst)
    cap_fire |=> ev_q[EV_CAP]); // R7
  AST_CAP_FLAG_KEEP: assert property (@(posedge clk) disable iff (rst)
    (ev_q[EV_CAP] && !(wr_ctrl && wr_strb[3] && wr_data[24])) |=> ev_q[EV_CAP]); // R8
  AST_DMA_ONLY_MATCH: assert property (@(posedge clk) disable iff (rst)
    dma_req |-> $past(match_hit)); // R6
endmodule

// File: tb/tb_mct_timer.sv
`timescale 1ns/1ps
module tb_mct_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_strb = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data;
  logic        tin = 1'b0;
  logic        tout;
  logic        irq;
  logic        dma_req;
  int n_checks = 0;
  int n_err = 0;

  localparam logic [1:0] W_CTRL = 2'd0;
  localparam logic [1:0] W_REF  = 2'd1;
  localparam logic [1:0] W_CAP  = 2'd2;
  localparam logic [1:0] W_CNT  = 2'd3;

  always #2.5 clk = ~clk;

  mct_timer dut (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_strb(wr_strb),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .tin(tin),
    .tout(tout), .irq(irq), .dma_req(dma_req)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(int ps, int edg, bit tg, bit ori, bit rs, int src, bit en);
    logic [7:0] p8 = ps[7:0];
    logic [1:0] e2 = edg[1:0];
    logic [1:0] s2 = src[1:0];
    return {16'h0, p8, e2, tg, ori, rs, s2, en};
  endfunction

  task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic [3:0] s);
    @(negedge clk);
    addr = a; wr_data = d; wr_strb = s; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wr_strb = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic wait_rise(input int limit, output int cyc);
    logic prev;
    prev = tout;
    cyc = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (!prev && tout) return;
      prev = tout;
      if (cyc >= limit) begin cyc = -1; return; end
    end
  endtask

  task automatic wait_change(input int limit, output int cyc);
    logic prev;
    prev = tout;
    cyc = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (tout !== prev) return;
      if (cyc >= limit) begin cyc = -1; return; end
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++;
    n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [31:0] v;
    logic [31:0] v2;
    logic [31:0] prev_cap;
    int c;
    int cnt_dma;
    int cnt_irq;

    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R11 reset state
    rd(W_CTRL, d); check("R11 reset control word", d, 0);
    rd(W_REF, d);  check("R11 reset reference", d, 0);
    rd(W_CAP, d);  check("R11 reset capture", d, 0);
    rd(W_CNT, d);  check("R11 reset counter", d, 0);
    check("R11 reset outputs", {29'b0, tout, irq, dma_req}, 0);

    // R11 readback and byte strobes (mode written with run bit clear)
    wr(W_CTRL, 32'hFF81_12C4, 4'hF);
    rd(W_CTRL, d); check("R11 control readback", d, 32'h0081_12C4);
    wr(W_REF, 32'hDEAD_BEEF, 4'b0101);
    rd(W_REF, d);  check("R11 reference byte strobes", d, 32'h00AD_00EF);
    wr(W_CTRL, 32'h0, 4'b0111);

    // R3 R4 R5 prescaler by reference sweep, restart mode, pulse output
    for (int ps = 0; ps < 4; ps++) begin
      for (int k = 0; k < 3; k++) begin
        int rv;
        rv = (k == 0) ? 1 : ((k == 1) ? 2 : 5);
        wr(W_CTRL, 32'h0, 4'b0011);
        wr(W_REF, rv, 4'hF);
        wr(W_CTRL, mk(ps, 0, 0, 0, 1, 1, 1), 4'b0011);
        wait_rise(200, c);
        wait_rise(200, c);
        check("R3 R4 restart period", c, (rv + 1) * (ps + 1));
        @(negedge clk);
        check("R5 single pulse width", {31'b0, tout}, 0);
      end
    end

    // R5 toggle output
    wr(W_CTRL, 32'h0, 4'b0011);
    wr(W_REF, 3, 4'hF);
    wr(W_CTRL, mk(1, 0, 1, 0, 1, 1, 1), 4'b0011);
    wait_change(200, c);
    wait_change(200, c);
    check("R5 toggle interval", c, 8);

    // R1 disable clears
    wr(W_CTRL, 32'h0, 4'b0011);
    check("R1 tout low when disabled", {31'b0, tout}, 0);
    rd(W_CNT, d); check("R1 counter zero when disabled", d, 0);

    // R2 divide-by-16 source
    wr(W_REF, 2, 4'hF);
    wr(W_CTRL, mk(1, 0, 0, 0, 1, 2, 1), 4'b0011);
    wait_rise(400, c);
    wait_rise(400, c);
    check("R2 div16 source period", c, 96);

    // R2 stop source freezes the count
    wr(W_CTRL, 32'h0, 4'b0011);
    wr(W_REF, 32'hFFFF_FFFF, 4'hF);
    wr(W_CTRL, mk(0, 0, 0, 0, 0, 1, 1), 4'b0011);
    repeat (30) @(negedge clk);
    wr(W_CTRL, mk(0, 0, 0, 0, 0, 0, 1), 4'b0011);
    repeat (3) @(negedge clk);
    rd(W_CNT, v);
    repeat (20) @(negedge clk);
    rd(W_CNT, v2);
    check("R2 count advanced before stop", {31'b0, (v >= 30)}, 1);
    check("R2 stopped count frozen", v2, v);

    // R4 free-run continues past the reference
    wr(W_CTRL, 32'h0, 4'b0011);
    wr(W_REF, 3, 4'hF);
    wr(W_CTRL, mk(0, 0, 0, 0, 0, 1, 1), 4'b0011);
    wait_rise(50, c);
    repeat (20) @(negedge clk);
    wr(W_CTRL, mk(0, 0, 0, 0, 0, 0, 1), 4'b0011);
    rd(W_CNT, d);
    check("R4 free-run passes reference", {31'b0, (d >= 23)}, 1);

    // R9 counter write clears count and prescaler phase
    wr(W_CTRL, 32'h0, 4'b0011);
    wr(W_REF, 2, 4'hF);
    wr(W_CTRL, mk(3, 0, 0, 0, 1, 1, 1), 4'b0011);
    repeat (13) @(negedge clk);
    wr(W_CNT, 32'hFFFF_FFFF, 4'hF);
    wait_rise(100, c);
    check("R9 first match after counter write", c, 2 * 4 + 1);
    wr(W_CTRL, mk(3, 0, 0, 0, 1, 0, 1), 4'b0011);
    repeat (3) @(negedge clk);
    wr(W_CNT, 32'h0, 4'b1000);
    rd(W_CNT, d); check("R9 counter reads zero after write", d, 0);

    // R2 R3 external pin source
    wr(W_CTRL, 32'h0, 4'b0011);
    tin = 1'b0;
    wr(W_REF, 32'hFFFF_FFFF, 4'hF);
    wr(W_CTRL, mk(1, 0, 0, 0, 0, 3, 1), 4'b0011);
    repeat (4) @(negedge clk);
    for (int i = 0; i < 10; i++) begin
      tin = 1'b1; repeat (4) @(negedge clk);
      tin = 1'b0; repeat (4) @(negedge clk);
    end
    repeat (6) @(negedge clk);
    rd(W_CNT, d); check("R2 R3 pin edges counted", d, 5);

    // R7 capture edge modes
    prev_cap = 0;
    for (int m = 0; m < 4; m++) begin
      bit er;
      bit ef;
      er = (m == 1) || (m == 3);
      ef = (m == 2) || (m == 3);
      wr(W_CTRL, 32'h0, 4'b0011);
      wr(W_CTRL, mk(0, 0, 0, 0, 0, 1, 1), 4'b0011);
      repeat (10 + 5 * m) @(negedge clk);
      wr(W_CTRL, mk(0, m, 0, 0, 0, 0, 1), 4'b0011);
      repeat (3) @(negedge clk);
      rd(W_CNT, v);
      wr(W_CTRL, 32'h0300_0000, 4'b1000);
      tin = 1'b1;
      repeat (6) @(negedge clk);
      rd(W_CAP, d);
      if (er) prev_cap = v;
      check("R7 capture value on rising edge", d, prev_cap);
      rd(W_CTRL, d);
      check("R7 capture flag on rising edge", {31'b0, d[24]}, {31'b0, er});
      wr(W_CTRL, 32'h0300_0000, 4'b1000);
      tin = 1'b0;
      repeat (6) @(negedge clk);
      rd(W_CAP, d);
      if (ef) prev_cap = v;
      check("R7 capture value on falling edge", d, prev_cap);
      rd(W_CTRL, d);
      check("R7 capture flag on falling edge", {31'b0, d[24]}, {31'b0, ef});
    end

    // R6 interrupt level, R8 write-one-to-clear
    wr(W_CTRL, 32'h0, 4'b0011);
    wr(W_CTRL, 32'h0300_0000, 4'b1000);
    wr(W_REF, 3, 4'hF);
    wr(W_CTRL, mk(0, 0, 0, 1, 1, 1, 1), 4'b0011);
    wait_rise(50, c);
    check("R6 irq follows match", {31'b0, irq}, 1);
    wr(W_CTRL, mk(0, 1, 0, 1, 1, 0, 1), 4'b0011);
    repeat (3) @(negedge clk);
    tin = 1'b1;
    repeat (6) @(negedge clk);
    rd(W_CTRL, d); check("R8 both events set", {30'b0, d[25:24]}, 3);
    wr(W_CTRL, 32'h0200_0000, 4'b1000);
    rd(W_CTRL, d); check("R8 clear reference flag only", {30'b0, d[25:24]}, 1);
    check("R6 irq drops with flag", {31'b0, irq}, 0);
    wr(W_CTRL, 32'h0100_0000, 4'b1000);
    rd(W_CTRL, d); check("R8 clear capture flag", {30'b0, d[25:24]}, 0);
    tin = 1'b0;
    repeat (6) @(negedge clk);

    // R6 request strobe mode
    wr(W_CTRL, 32'h0, 4'b0011);
    wr(W_CTRL, 32'h0080_0000, 4'b0100);
    wr(W_REF, 4, 4'hF);
    wr(W_CTRL, mk(0, 0, 0, 1, 1, 1, 1), 4'b0011);
    repeat (20) @(negedge clk);
    cnt_dma = 0;
    cnt_irq = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (dma_req) cnt_dma++;
      if (irq) cnt_irq++;
    end
    check("R6 request pulses per window", cnt_dma, 20);
    check("R6 irq suppressed in request mode", cnt_irq, 0);

    // R10 narrow mode: masked compare and 16-bit wrap
    wr(W_CTRL, 32'h0, 4'b0011);
    wr(W_CTRL, 32'h0001_0000, 4'b0100);
    wr(W_REF, 32'h0001_0002, 4'hF);
    wr(W_CTRL, mk(0, 0, 0, 0, 0, 1, 1), 4'b0011);
    wait_rise(20, c);
    check("R10 masked reference compare", {31'b0, (c > 0)}, 1);
    wait_rise(70000, c);
    check("R10 wrap period", c, 65536);
    wr(W_CTRL, 32'h0, 4'b0111);

    $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end
endmodule